// File: doc/BRIEF.md
# Block-Transfer Bus Sequencer

This block drives the memory interface of a pipelined 32-bit core while it executes three kinds of instruction: a multi-register load, a multi-register store, and a single-register store. A one-cycle start pulse hands over the operation, a register mask, the base address computed by the ALU, the current PC, the privilege level and a user-translation override. From then on the sequencer produces, cycle by cycle, the bus address, transfer size, write strobe, active-low memory request, sequential hint, active-low opcode-fetch flag and translation flag. It also issues register-file writes, base-writeback and base-restore pulses, and a pipeline flush.

Every operation opens with an opcode prefetch. A load then reads one word per listed register and finishes with an internal cycle. When the PC is among the loaded registers, two refill fetches at the new PC follow. A store writes one word per listed register and has no internal cycle. A data abort during a load does not stop the sequence. It only blocks the register writes from that word onward and turns the final cycle into a base restore.

The memory request and sequential hint describe the next cycle, not the current one. This lets the memory system prepare a burst or an idle slot in advance.

Top module: `blkx_seq`

## Requirements
- R1: The first cycle after an accepted start is an opcode prefetch at pc+8 (twice the 4-byte instruction length). In it: word size (code 2), wr=0, mreq_n=0, seq=0, opc_n=0.
- R2: The first data transfer uses the base address. Each further transfer is at the previous address plus 4. Block transfers use word size (code 2). opc_n is 1 on every data cycle.
- R3: A single-register store (op_single=1) takes exactly two cycles. The second cycle writes at the base address with size st_size, wr=1, mreq_n=0, seq=0, base_wb=1, and stores the lowest-numbered register in the mask. busy is low in the next cycle.
- R4: A load of n registers performs n reads (wr=0) and then one internal cycle at pc+12 with opc_n=1 and mreq_n=0. The last read has mreq_n=1 and seq=0. The internal cycle has seq=1, or seq=0 when a PC refill follows.
- R5: A store of n registers performs n writes (wr=1) and no internal cycle. The last write has mreq_n=0 and seq=0.
- R6: Every data transfer except the last of its operation has mreq_n=0 and seq=1.
- R7: When register 15 (the PC) is in the load mask and no abort occurred, the internal cycle asserts flush. Two fetches with opc_n=0, mreq_n=0 and seq=1 then follow: one at the loaded PC word and one at that word plus 4.
- R8: After an abort on the j-th read of a load, the sequence still runs to its end. No register write is issued for word j or any later word. The internal cycle asserts base_restore, and no PC refill takes place.
- R9: trans equals the privilege flag (0 for user, 1 otherwise) in every cycle, except the data cycle of a single store with user_xlat=1, where it is 0.
- R10: Registers are transferred in ascending index order. The word read in a load cycle is written to its register (rf_waddr = index, rf_wdata = word) in the following cycle. During each store write, st_reg holds the index of the register being stored.
- R11: busy is high from the cycle after an accepted start through the last cycle of the operation and low afterwards. A start while busy is ignored. A start with an empty mask is ignored.
- R12: base_wb pulses exactly once per operation, in the first data-transfer cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse for a new operation |
| op_load | input | 1 | 1 = multi-register load, 0 = store |
| op_single | input | 1 | 1 = single-register store (overrides op_load) |
| reg_list | input | 16 | Register mask, bit i selects register i |
| st_size | input | 2 | Transfer size code for a single store |
| base_addr | input | 32 | ALU-computed first data address |
| pc | input | 32 | Current PC |
| priv | input | 1 | 0 = user mode, 1 = privileged |
| user_xlat | input | 1 | Force user translation on a single store |
| abort | input | 1 | Data abort for the current transfer |
| rdata | input | 32 | Read data for the current transfer |
| addr | output | 32 | Bus address |
| size | output | 2 | Transfer size code |
| wr | output | 1 | 1 = write, 0 = read |
| mreq_n | output | 1 | Active-low: next cycle is a memory cycle |
| seq | output | 1 | Next cycle is sequential to this one |
| opc_n | output | 1 | Active-low opcode-fetch flag |
| trans | output | 1 | Translation (non-user) flag |
| busy | output | 1 | Operation in progress |
| st_reg | output | 4 | Register index supplying store data |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 4 | Register-file write index |
| rf_wdata | output | 32 | Register-file write data |
| base_wb | output | 1 | Base writeback request |
| base_restore | output | 1 | Restore the written-back base after an abort |
| flush | output | 1 | Invalidate the instruction pipeline |

## Verification
The bench builds the sequencer with its default parameters: a 16-entry register mask, 32-bit addresses and data, and a 4-byte instruction length. With these values the full mask is reachable, so 16-word bursts occur. Register 15 is the final and PC slot, so refills, aborts on the PC word itself, and mixes of abort and PC load can all be driven through the ports and compared with traces computed independently per cycle.

// File: rtl/blkx_pkg.sv
package blkx_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_PREF, S_XFER, S_INTL, S_REF1, S_REF2
  } seq_state_e;

  typedef struct packed {
    logic wr;
    logic mreq_n;
    logic seq;
    logic opc_n;
  } strobe_t;

  localparam logic [1:0] SZ_WORD = 2'd2;
endpackage

// File: rtl/blkx_pick.sv
module blkx_pick #(
  parameter int NREG = 16,
  localparam int IW = $clog2(NREG)
) (
  input  logic [NREG-1:0] list,
  output logic [NREG-1:0] low_oh,
  output logic [IW-1:0]   idx,
  output logic            last
);
  logic [NREG-1:0] below_any;

  genvar gi;
  generate
    for (gi = 0; gi < NREG; gi++) begin : g_bit
      if (gi == 0) begin : g_first
        assign below_any[gi] = 1'b0;
      end else begin : g_rest
        assign below_any[gi] = |list[gi-1:0];
      end
      assign low_oh[gi] = list[gi] & ~below_any[gi];
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int i = 0; i < NREG; i++)
      if (low_oh[i]) idx = idx | IW'(i);
  end

  assign last = ~|(list & ~low_oh);
endmodule

// File: rtl/blkx_agen.sv
module blkx_agen #(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic          adv,
  output logic [AW-1:0] xaddr
);
  function automatic logic [AW-1:0] next_word(input logic [AW-1:0] a);
    return a + AW'(STEP);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    xaddr <= '0;
    else if (load) xaddr <= base;
    else if (adv)  xaddr <= next_word(xaddr);
  end
endmodule

// File: rtl/blkx_strobe.sv
module blkx_strobe
  import blkx_pkg::*;
(
  input  seq_state_e st,
  input  logic       is_load,
  input  logic       is_single,
  input  logic       last,
  input  logic       refill,
  output strobe_t    sb
);
  logic end_x;
  assign end_x = last | is_single;

  always_comb begin
    sb = '{wr: 1'b0, mreq_n: 1'b1, seq: 1'b0, opc_n: 1'b0};
    case (st)
      S_PREF: sb = '{wr: 1'b0, mreq_n: 1'b0, seq: 1'b0, opc_n: 1'b0};
      S_XFER: begin
        sb.wr     = ~is_load | is_single;
        sb.mreq_n = is_load & ~is_single & end_x;
        sb.seq    = ~end_x;
        sb.opc_n  = 1'b1;
      end
      S_INTL: sb = '{wr: 1'b0, mreq_n: 1'b0, seq: ~refill, opc_n: 1'b1};
      S_REF1, S_REF2: sb = '{wr: 1'b0, mreq_n: 1'b0, seq: 1'b1, opc_n: 1'b0};
      default: ;
    endcase
  end
endmodule

// File: rtl/blkx_seq.sv
module blkx_seq
  import blkx_pkg::*;
#(
  parameter int NREG       = 16,
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int INSN_BYTES = 4,
  parameter int WORD_BYTES = 4,
  localparam int IW        = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            op_load,
  input  logic            op_single,
  input  logic [NREG-1:0] reg_list,
  input  logic [1:0]      st_size,
  input  logic [AW-1:0]   base_addr,
  input  logic [AW-1:0]   pc,
  input  logic            priv,
  input  logic            user_xlat,
  input  logic            abort,
  input  logic [DW-1:0]   rdata,
  output logic [AW-1:0]   addr,
  output logic [1:0]      size,
  output logic            wr,
  output logic            mreq_n,
  output logic            seq,
  output logic            opc_n,
  output logic            trans,
  output logic            busy,
  output logic [IW-1:0]   st_reg,
  output logic            rf_we,
  output logic [IW-1:0]   rf_waddr,
  output logic [DW-1:0]   rf_wdata,
  output logic            base_wb,
  output logic            base_restore,
  output logic            flush
);
  localparam logic [IW-1:0] PC_IDX = IW'(NREG - 1);

  function automatic logic [AW-1:0] pc_ahead(input logic [AW-1:0] p, input int slots);
    return p + AW'(slots * INSN_BYTES);
  endfunction

  seq_state_e      state, state_nx;
  logic [NREG-1:0] rem, low_oh;
  logic [IW-1:0]   cur_idx;
  logic            is_last;
  logic            op_ld_r, op_sg_r, priv_r, ux_r, first_r, ab_r;
  logic [1:0]      size_r;
  logic [AW-1:0]   pc_r, pc_tgt, xaddr;
  logic            pend;
  logic [IW-1:0]   widx;
  logic [DW-1:0]   wdata;
  strobe_t         sb;

  // named internal events
  logic accept, in_xfer, ld_xfer, pc_wr, xfer_done;
  assign busy      = (state != S_IDLE);
  assign accept    = start & ~busy & (|reg_list);
  assign in_xfer   = (state == S_XFER);
  assign ld_xfer   = in_xfer & op_ld_r;
  assign pc_wr     = pend & (widx == PC_IDX);
  assign xfer_done = in_xfer & (op_sg_r | is_last);

  blkx_pick #(.NREG(NREG)) u_pick (
    .list(rem), .low_oh(low_oh), .idx(cur_idx), .last(is_last)
  );

  blkx_agen #(.AW(AW), .STEP(WORD_BYTES)) u_agen (
    .clk(clk), .rst_n(rst_n), .load(accept), .base(base_addr),
    .adv(in_xfer), .xaddr(xaddr)
  );

  blkx_strobe u_strobe (
    .st(state), .is_load(op_ld_r), .is_single(op_sg_r),
    .last(is_last), .refill(pc_wr), .sb(sb)
  );

  always_comb begin
    state_nx = state;
    case (state)
      S_IDLE: if (accept) state_nx = S_PREF;
      S_PREF: state_nx = S_XFER;
      S_XFER: if (xfer_done) state_nx = (op_ld_r & ~op_sg_r) ? S_INTL : S_IDLE;
      S_INTL: state_nx = pc_wr ? S_REF1 : S_IDLE;
      S_REF1: state_nx = S_REF2;
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      rem <= '0;
      op_ld_r <= 1'b0; op_sg_r <= 1'b0; priv_r <= 1'b0; ux_r <= 1'b0;
      first_r <= 1'b0; ab_r <= 1'b0; size_r <= '0;
      pc_r <= '0; pc_tgt <= '0;
      pend <= 1'b0; widx <= '0; wdata <= '0;
    end else begin
      state <= state_nx;
      if (accept) begin
        rem     <= reg_list;
        op_ld_r <= op_load & ~op_single;
        op_sg_r <= op_single;
        priv_r  <= priv;
        ux_r    <= user_xlat;
        size_r  <= st_size;
        pc_r    <= pc;
        first_r <= 1'b1;
        ab_r    <= 1'b0;
      end else if (in_xfer) begin
        rem     <= rem & ~low_oh;
        first_r <= 1'b0;
        if (op_ld_r && abort) ab_r <= 1'b1;
      end
      pend  <= ld_xfer & ~ab_r & ~abort;
      widx  <= cur_idx;
      wdata <= rdata;
      if (ld_xfer && cur_idx == PC_IDX) pc_tgt <= rdata;
    end
  end

  always_comb begin
    case (state)
      S_PREF:  addr = pc_ahead(pc_r, 2);
      S_XFER:  addr = xaddr;
      S_INTL:  addr = pc_ahead(pc_r, 3);
      S_REF1:  addr = pc_tgt;
      S_REF2:  addr = pc_ahead(pc_tgt, 1);
      default: addr = '0;
    endcase
  end

  assign size         = (in_xfer & op_sg_r) ? size_r : SZ_WORD;
  assign wr           = sb.wr;
  assign mreq_n       = sb.mreq_n;
  assign seq          = sb.seq;
  assign opc_n        = sb.opc_n;
  assign trans        = priv_r & ~(in_xfer & op_sg_r & ux_r);
  assign st_reg       = cur_idx;
  assign rf_we        = pend;
  assign rf_waddr     = widx;
  assign rf_wdata     = wdata;
  assign base_wb      = in_xfer & first_r;
  assign base_restore = (state == S_INTL) & ab_r;
  assign flush        = (state == S_INTL) & pc_wr;

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_xfer && $past(state) == S_XFER) |-> addr == $past(addr) + AW'(WORD_BYTES)); // R2
  AST_SINGLE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_xfer && op_sg_r) |=> !busy); // R3
  AST_LAST_READ_IDLE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_INTL) |-> ($past(mreq_n) && !$past(seq))); // R4
  AST_REFILL_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (state == S_REF1 && !opc_n && seq)); // R7
  AST_NO_WRITE_AFTER_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    ab_r |-> !rf_we); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> state != S_PREF); // R11
  AST_WB_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    base_wb |=> !base_wb); // R12
endmodule

// File: tb/blkx_seq_test.sv
`timescale 1ns/1ps
module blkx_seq_test;
  localparam time CLK_P = 20ns;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 0, op_load = 0, op_single = 0, priv = 0, user_xlat = 0, abort = 0;
  logic [15:0] reg_list = '0;
  logic [1:0]  st_size = '0;
  logic [31:0] base_addr = '0, pc = '0, rdata = '0;
  logic [31:0] addr, rf_wdata;
  logic [1:0]  size;
  logic        wr, mreq_n, seq, opc_n, trans, busy, rf_we, base_wb, base_restore, flush;
  logic [3:0]  st_reg, rf_waddr;

  int n_chk = 0, n_fail = 0;

  blkx_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_load(op_load), .op_single(op_single),
    .reg_list(reg_list), .st_size(st_size), .base_addr(base_addr), .pc(pc),
    .priv(priv), .user_xlat(user_xlat), .abort(abort), .rdata(rdata),
    .addr(addr), .size(size), .wr(wr), .mreq_n(mreq_n), .seq(seq), .opc_n(opc_n),
    .trans(trans), .busy(busy), .st_reg(st_reg), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .base_wb(base_wb), .base_restore(base_restore), .flush(flush)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'h9E37_79B9) ^ 32'h5A5A_0000;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ld/sg select op, abk = index (1-based) of aborting read, 0 for none
  task automatic run_op(input bit ld, input bit sg, input logic [15:0] lst,
                        input logic [1:0] sz, input logic [31:0] bs, input logic [31:0] pcv,
                        input bit pr, input bit ux, input int abk, input bit poke);
    int n = $countones(lst);
    int idx[16];
    int c = 0;
    bit is_ld = ld && !sg;
    bit pcl = is_ld && lst[15] && abk == 0;
    int total = sg ? 2 : (is_ld ? n + 2 + (pcl ? 2 : 0) : n + 1);
    logic [31:0] pct = mem_word(bs + 32'(4 * (n - 1)));
    for (int i = 0; i < 16; i++) if (lst[i]) begin idx[c] = i; c++; end
    @(negedge clk);
    op_load = ld; op_single = sg; reg_list = lst; st_size = sz;
    base_addr = bs; pc = pcv; priv = pr; user_xlat = ux; start = 1;
    if (n == 0) begin
      @(negedge clk); start = 0;
      chk("R11 empty mask ignored", {63'd0, busy}, 64'd0);
      @(negedge clk);
      chk("R11 empty mask still idle", {63'd0, busy}, 64'd0);
      return;
    end
    for (int k = 1; k <= total; k++) begin
      logic [31:0] ea; logic [1:0] es; logic ew, em, eq, eo, et;
      logic ewe, ebw, ers, efl; logic [3:0] ewa; logic [31:0] ewd;
      string tg;
      @(negedge clk);
      start = (poke && k == 2);
      reg_list = (poke && k == 2) ? 16'hFFFF : lst;
      ea = 0; es = 2'd2; ew = 0; em = 0; eq = 0; eo = 0; et = pr;
      if (k == 1) begin ea = pcv + 32'd8; tg = "R1"; end
      else if (sg) begin ea = bs; es = sz; ew = 1; eo = 1; et = pr & ~ux; tg = "R3/R9"; end
      else if (k <= n + 1) begin
        ea = bs + 32'(4 * (k - 2)); eo = 1; ew = !is_ld;
        eq = (k - 1 != n); em = is_ld && (k - 1 == n);
        tg = is_ld ? "R4/R2/R6" : "R5/R2/R6";
      end
      else if (k == n + 2) begin ea = pcv + 32'd12; eo = 1; eq = !pcl; tg = "R4 internal"; end
      else if (k == n + 3) begin ea = pct; eq = 1; tg = "R7 refill1"; end
      else begin ea = pct + 32'd4; eq = 1; tg = "R7 refill2"; end
      abort = is_ld && abk != 0 && (k == abk + 1);
      rdata = mem_word(ea);
      #2;
      chk(tg, {24'd0, addr, size, wr, mreq_n, seq, opc_n, trans, busy},
              {24'd0, ea, es, ew, em, eq, eo, et, 1'b1});
      ewe = is_ld && k >= 3 && k <= n + 2 && (abk == 0 || k - 2 < abk);
      ewa = ewe ? 4'(idx[k-3]) : 4'd0;
      ewd = ewe ? mem_word(bs + 32'(4 * (k - 3))) : 32'd0;
      chk(ewe ? "R10 rf write" : "R8 rf quiet",
          {27'd0, rf_we, ewe ? rf_waddr : 4'd0, ewe ? rf_wdata : 32'd0},
          {27'd0, ewe, ewa, ewd});
      ebw = (k == 2);
      ers = is_ld && k == n + 2 && abk != 0;
      efl = pcl && k == n + 2;
      chk("R12/R8/R7 control pulses", {61'd0, base_wb, base_restore, flush},
          {61'd0, ebw, ers, efl});
      if (ew) chk("R10 store reg order", {60'd0, st_reg}, {60'd0, 4'(idx[k-2])});
    end
    @(negedge clk);
    start = 0; abort = 0; reg_list = lst;
    #2 chk("R11 busy drops after last cycle", {62'd0, busy, base_wb}, 64'd0);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R11 reset idle", {59'd0, busy, mreq_n, rf_we, base_wb, flush}, {59'd0, 5'b01000});
    rst_n = 1;
    // directed corners
    run_op(0, 1, 16'h0030, 2'd1, 32'h0000_1000, 32'h0000_8000, 1, 1, 0, 0); // R3 R9 user override
    run_op(0, 1, 16'h0004, 2'd0, 32'h0000_2000, 32'h0000_8000, 1, 0, 0, 0); // R3
    run_op(1, 0, 16'h0008, 2'd2, 32'h0000_3000, 32'h0000_0100, 0, 0, 0, 0); // R4 single reg
    run_op(1, 0, 16'h8000, 2'd2, 32'h0000_3100, 32'h0000_0200, 1, 0, 0, 0); // R7 pc only
    run_op(1, 0, 16'hFFFF, 2'd2, 32'h0000_4000, 32'h0000_0300, 1, 0, 0, 1); // R7 R11 poke
    run_op(1, 0, 16'h8421, 2'd2, 32'h0000_5000, 32'h0000_0400, 1, 0, 4, 0); // R8 abort on pc
    run_op(1, 0, 16'h00F0, 2'd2, 32'h0000_5800, 32'h0000_0500, 0, 0, 2, 0); // R8 mid abort
    run_op(0, 0, 16'hFFFF, 2'd2, 32'h0000_6000, 32'h0000_0600, 1, 1, 0, 1); // R5 R9
    run_op(0, 0, 16'h0000, 2'd2, 32'h0000_7000, 32'h0000_0700, 0, 0, 0, 0); // R11 empty
    // constrained random
    for (int t = 0; t < 60; t++) begin
      bit ld = 1'($urandom_range(0, 1));
      bit sg = !ld && ($urandom_range(0, 3) == 0);
      logic [15:0] l = 16'($urandom());
      int nn, ab;
      if ($urandom_range(0, 2) == 0) l = l & 16'h80F3;
      nn = $countones(l);
      ab = (ld && nn > 0 && $urandom_range(0, 2) == 0) ? $urandom_range(1, nn) : 0;
      run_op(ld, sg, l, 2'($urandom_range(0, 2)), {$urandom_range(0, 65535), 2'b00} & 32'h0003_FFFC,
             {$urandom_range(0, 65535), 2'b00} & 32'h0003_FFFC,
             1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), ab, 1'($urandom_range(0, 1)));
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule